// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block is the hazard-detection unit of a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. It looks at the register fields and control flags of the instructions in decode, execute and memory, and decides each cycle whether the front end must freeze and a bubble enter execute. It also decides whether the instruction just fetched must be discarded because a branch resolved in decode was taken. The block is purely combinational. Its outputs go straight to the program counter enable, the enable and clear of the fetch/decode pipeline register, and the clear of the control fields in the decode/execute register.

Two sources of stall are combined. A load-use stall covers an instruction that reads the result of a load one slot ahead. After one bubble, the loaded value can be forwarded from the writeback-side register into execute. A branch-operand stall covers a branch in decode: it compares its operands in decode, so it must wait for an ALU result still in execute, or for a load result still in memory. Register index 0 is hard-wired to zero, so it never creates a dependency.

Top module: `pipe_stall_ctl`

## Requirements
- R1: When the execute instruction reads memory (`exe_mem_rd_i`=1) and its `exe_rt_i` is nonzero and equals `dec_rs_i` or `dec_rt_i`, a stall is raised.
- R2: When `dec_branch_i`=1, the execute instruction writes a register (`exe_reg_wr_i`=1), and the nonzero `exe_dst_i` equals `dec_rs_i` or `dec_rt_i`, a stall is raised.
- R3: When `dec_branch_i`=1, the memory instruction is a load (`mem_to_reg_i`=1), and the nonzero `mem_dst_i` equals `dec_rs_i` or `dec_rt_i`, a stall is raised.
- R4: `pc_hold_o`, `ifid_hold_o` and `idex_zero_o` are always equal, and they are 1 exactly when at least one of R1, R2 or R3 holds.
- R5: A producer whose register index is 0 never causes a stall, whatever the source fields and flags are.
- R6: `ifid_zero_o` is 1 exactly when `dec_br_taken_i`=1 and no stall is raised in the same cycle.
- R7: If the decode instruction is not a branch, the execute destination and the memory-stage fields have no effect. Only the load-use condition of R1 can stall it.
- R8: A load-use stall needs no second cycle. Once the bubble has replaced the load in execute, the same non-branch decode instruction proceeds, even though the load now sits in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs_i | input | IDX_W | First source register index of the decode instruction |
| dec_rt_i | input | IDX_W | Second source register index of the decode instruction |
| dec_branch_i | input | 1 | Decode instruction is a conditional branch |
| dec_br_taken_i | input | 1 | Branch compared in decode is taken |
| exe_rt_i | input | IDX_W | rt field of the execute instruction (load target) |
| exe_dst_i | input | IDX_W | Destination register of the execute instruction |
| exe_mem_rd_i | input | 1 | Execute instruction reads data memory |
| exe_reg_wr_i | input | 1 | Execute instruction writes the register file |
| mem_dst_i | input | IDX_W | Destination register of the memory-stage instruction |
| mem_to_reg_i | input | 1 | Memory-stage instruction writes loaded data to a register |
| pc_hold_o | output | 1 | Keep the program counter unchanged |
| ifid_hold_o | output | 1 | Keep the fetch/decode register unchanged |
| idex_zero_o | output | 1 | Clear control fields entering execute (bubble) |
| ifid_zero_o | output | 1 | Clear the fetched instruction after a taken branch |

## Verification
The hardest case to reach is a branch placed one slot behind a load of its own operand. It must stall twice in a row: first from the execute-stage match, then from the memory-stage load match after the bubble. A taken indication during those cycles must not discard the held instruction. The bench first drives a short cycle-by-cycle sequence that models the pipeline advancing, so that the load moves from execute to memory while the branch stays in decode. It then sweeps every combination of fields and flags at a 2-bit register index, which also reaches all zero-index and coincident-match cases.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int unsigned DEF_IDX_W = 5;

    // Producer slots compared against the decode sources
    localparam int unsigned NPROD  = 3;
    localparam int unsigned P_LOAD = 0;  // load in execute vs any decode source
    localparam int unsigned P_BEXE = 1;  // register writer in execute vs branch
    localparam int unsigned P_BMEM = 2;  // load in memory vs branch

    typedef struct packed {
        logic hold_pc;
        logic hold_ifid;
        logic zero_idex;
        logic zero_ifid;
    } hz_ctrl_t;

    function automatic logic src_hit(input logic [31:0] dst,
                                     input logic [31:0] rs,
                                     input logic [31:0] rt);
        return (dst != 32'd0) && ((dst == rs) || (dst == rt));
    endfunction

endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
    parameter int unsigned IDX_W = hzd_pkg::DEF_IDX_W
) (
    input  logic [IDX_W-1:0] dst_i,
    input  logic             qual_i,
    input  logic [IDX_W-1:0] rs_i,
    input  logic [IDX_W-1:0] rt_i,
    output logic             hit_o
);
    import hzd_pkg::*;

    localparam int unsigned PAD = 32 - IDX_W;

    always_comb begin
        hit_o = qual_i && src_hit({{PAD{1'b0}}, dst_i},
                                  {{PAD{1'b0}}, rs_i},
                                  {{PAD{1'b0}}, rt_i});
    end
endmodule

// File: rtl/hzd_resolve.sv
module hzd_resolve #(
    parameter int unsigned NP = hzd_pkg::NPROD
) (
    input  logic [NP-1:0]     hit_i,
    input  logic              taken_i,
    output hzd_pkg::hz_ctrl_t ctrl_o
);
    logic stall;

    always_comb begin
        stall            = |hit_i;
        ctrl_o.hold_pc   = stall;
        ctrl_o.hold_ifid = stall;
        ctrl_o.zero_idex = stall;
        // a stalled branch compared stale operands; keep the held fetch
        ctrl_o.zero_ifid = taken_i && !stall;
    end
endmodule

// File: rtl/pipe_stall_ctl.sv
module pipe_stall_ctl #(
    parameter int unsigned IDX_W = hzd_pkg::DEF_IDX_W
) (
    input  logic [IDX_W-1:0] dec_rs_i,
    input  logic [IDX_W-1:0] dec_rt_i,
    input  logic             dec_branch_i,
    input  logic             dec_br_taken_i,
    input  logic [IDX_W-1:0] exe_rt_i,
    input  logic [IDX_W-1:0] exe_dst_i,
    input  logic             exe_mem_rd_i,
    input  logic             exe_reg_wr_i,
    input  logic [IDX_W-1:0] mem_dst_i,
    input  logic             mem_to_reg_i,
    output logic             pc_hold_o,
    output logic             ifid_hold_o,
    output logic             idex_zero_o,
    output logic             ifid_zero_o
);
    import hzd_pkg::*;

    logic [NPROD-1:0][IDX_W-1:0] prod_dst;
    logic [NPROD-1:0]            prod_qual;
    logic [NPROD-1:0]            prod_hit;
    hz_ctrl_t                    ctrl;

    always_comb begin
        prod_dst[P_LOAD]  = exe_rt_i;
        prod_qual[P_LOAD] = exe_mem_rd_i;
        prod_dst[P_BEXE]  = exe_dst_i;
        prod_qual[P_BEXE] = dec_branch_i && exe_reg_wr_i;
        prod_dst[P_BMEM]  = mem_dst_i;
        prod_qual[P_BMEM] = dec_branch_i && mem_to_reg_i;
    end

    for (genvar p = 0; p < NPROD; p++) begin : g_prod
        hzd_src_match #(.IDX_W(IDX_W)) u_match (
            .dst_i  (prod_dst[p]),
            .qual_i (prod_qual[p]),
            .rs_i   (dec_rs_i),
            .rt_i   (dec_rt_i),
            .hit_o  (prod_hit[p])
        );
    end

    hzd_resolve #(.NP(NPROD)) u_resolve (
        .hit_i   (prod_hit),
        .taken_i (dec_br_taken_i),
        .ctrl_o  (ctrl)
    );

    assign pc_hold_o   = ctrl.hold_pc;
    assign ifid_hold_o = ctrl.hold_ifid;
    assign idex_zero_o = ctrl.zero_idex;
    assign ifid_zero_o = ctrl.zero_ifid;

endmodule

// File: rtl/pipe_stall_ctl_chk.sv
module pipe_stall_ctl_chk #(
    parameter int unsigned IDX_W = 5
) (
    input logic [IDX_W-1:0] dec_rs_i,
    input logic [IDX_W-1:0] dec_rt_i,
    input logic             dec_branch_i,
    input logic             dec_br_taken_i,
    input logic [IDX_W-1:0] exe_rt_i,
    input logic [IDX_W-1:0] exe_dst_i,
    input logic             exe_mem_rd_i,
    input logic             exe_reg_wr_i,
    input logic [IDX_W-1:0] mem_dst_i,
    input logic             mem_to_reg_i,
    input logic             pc_hold_o,
    input logic             ifid_hold_o,
    input logic             idex_zero_o,
    input logic             ifid_zero_o
);
    always_comb begin
        if (exe_mem_rd_i && exe_rt_i != '0 && exe_rt_i == dec_rs_i)
            AST_LOAD_USE_STALL: assert (idex_zero_o) else $error("load-use missed"); // R1
        if (dec_branch_i && exe_reg_wr_i && exe_dst_i != '0 && exe_dst_i == dec_rt_i)
            AST_BR_EXE_STALL: assert (pc_hold_o) else $error("branch/exe missed"); // R2
        if (dec_branch_i && mem_to_reg_i && mem_dst_i != '0 && mem_dst_i == dec_rs_i)
            AST_BR_MEM_STALL: assert (ifid_hold_o) else $error("branch/mem missed"); // R3
        AST_HOLDS_AGREE: assert (pc_hold_o == ifid_hold_o && ifid_hold_o == idex_zero_o)
            else $error("hold outputs disagree"); // R4
        if (exe_rt_i == '0 && exe_dst_i == '0 && mem_dst_i == '0)
            AST_ZERO_IDX_QUIET: assert (!pc_hold_o) else $error("stall on index 0"); // R5
        AST_FLUSH_NOT_HELD: assert (!(ifid_zero_o && ifid_hold_o))
            else $error("flush during hold"); // R6
        if (!dec_branch_i && !exe_mem_rd_i)
            AST_NONBRANCH_FREE: assert (!pc_hold_o) else $error("non-branch stalled"); // R7
    end
endmodule

bind pipe_stall_ctl pipe_stall_ctl_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_pipe_stall_ctl.sv
module test_pipe_stall_ctl;
    localparam int unsigned W = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic [W-1:0] rs, rt, ert, edst, mdst;
    logic         br, tk, emr, ewr, m2r;
    logic         pc_hold, ifid_hold, idex_zero, ifid_zero;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    pipe_stall_ctl #(.IDX_W(W)) i_pipe_stall_ctl (
        .dec_rs_i(rs), .dec_rt_i(rt), .dec_branch_i(br), .dec_br_taken_i(tk),
        .exe_rt_i(ert), .exe_dst_i(edst), .exe_mem_rd_i(emr), .exe_reg_wr_i(ewr),
        .mem_dst_i(mdst), .mem_to_reg_i(m2r),
        .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold),
        .idex_zero_o(idex_zero), .ifid_zero_o(ifid_zero)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (rs=%0d rt=%0d br=%b tk=%b ert=%0d edst=%0d emr=%b ewr=%b mdst=%0d m2r=%b)",
                     tag, act, exp, rs, rt, br, tk, ert, edst, emr, ewr, mdst, m2r);
        end
    endtask

    task automatic drive(input int r_s, input int r_t, input bit b, input bit t,
                         input int e_rt, input int e_d, input bit e_mr, input bit e_wr,
                         input int m_d, input bit m_r);
        @(posedge clk);
        rs = r_s[W-1:0]; rt = r_t[W-1:0]; br = b; tk = t;
        ert = e_rt[W-1:0]; edst = e_d[W-1:0]; emr = e_mr; ewr = e_wr;
        mdst = m_d[W-1:0]; m2r = m_r;
        @(negedge clk);
    endtask

    task automatic chk_all(input string tag, input bit stall, input bit flush);
        chk({tag, " pc_hold"},   pc_hold,   stall);
        chk({tag, " ifid_hold"}, ifid_hold, stall);
        chk({tag, " idex_zero"}, idex_zero, stall);
        chk({tag, " ifid_zero"}, ifid_zero, flush);
    endtask

    initial begin
        // idle state: nothing in flight
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk_all("R4 idle", 1'b0, 1'b0);

        // load r1 then dependent add r1,r2
        drive(1, 2, 0, 0, 1, 1, 1, 1, 0, 0);
        chk_all("R1 load-use", 1'b1, 1'b0);
        // bubble in execute, load now in memory: one stall only
        drive(1, 2, 0, 0, 0, 0, 0, 0, 1, 1);
        chk_all("R8 single stall", 1'b0, 1'b0);
        // dependency through rt
        drive(3, 2, 0, 0, 2, 2, 1, 1, 0, 0);
        chk_all("R1 load-use rt", 1'b1, 1'b0);
        // load into r0 never stalls
        drive(0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
        chk_all("R5 load r0", 1'b0, 1'b0);

        // branch on r3 after ALU op writing r3, taken
        drive(3, 0, 1, 1, 0, 3, 0, 1, 0, 0);
        chk_all("R2 branch after alu", 1'b1, 1'b0);
        drive(3, 0, 1, 1, 0, 0, 0, 0, 3, 0);
        chk_all("R6 branch resolves", 1'b0, 1'b1);

        // branch on r1 one slot after load of r1
        drive(1, 2, 1, 1, 1, 1, 1, 1, 0, 0);
        chk_all("R1/R2 branch after load", 1'b1, 1'b0);
        drive(1, 2, 1, 1, 0, 0, 0, 0, 1, 1);
        chk_all("R3 branch second stall", 1'b1, 1'b0);
        drive(1, 2, 1, 1, 0, 0, 0, 0, 0, 0);
        chk_all("R6 branch after load resolves", 1'b0, 1'b1);

        // non-branch ignores exe destination and memory load
        drive(2, 3, 0, 0, 0, 2, 0, 1, 3, 1);
        chk_all("R7 non-branch", 1'b0, 1'b0);

        // exhaustive sweep
        for (int v = 0; v < (1 << (5 * W + 5)); v++) begin
            bit el, ee, em, st, fl;
            int a_rs, a_rt, a_ert, a_ed, a_md;
            string tg;
            a_rs  = v & 3;         a_rt = (v >> 2) & 3;
            a_ert = (v >> 4) & 3;  a_ed = (v >> 6) & 3;
            a_md  = (v >> 8) & 3;
            drive(a_rs, a_rt, v[10], v[11], a_ert, a_ed, v[12], v[13], a_md, v[14]);
            el = v[12] && a_ert != 0 && (a_ert == a_rs || a_ert == a_rt);
            ee = v[10] && v[13] && a_ed != 0 && (a_ed == a_rs || a_ed == a_rt);
            em = v[10] && v[14] && a_md != 0 && (a_md == a_rs || a_md == a_rt);
            st = el || ee || em;
            fl = v[11] && !st;
            tg = el ? "R1" : ee ? "R2" : em ? "R3" : (v[10] ? "R5" : "R7");
            chk({tg, " R4 pc_hold"},   pc_hold,   st);
            chk({tg, " R4 ifid_hold"}, ifid_hold, st);
            chk({tg, " R4 idex_zero"}, idex_zero, st);
            chk("R6 ifid_zero",        ifid_zero, fl);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule